// File: doc/BRIEF.md
# Parallel Port Acknowledge Interrupt and Register Slice

This block is the register slice of a standard parallel port: an output data latch, a control register and a status view. A host reaches them over a simple synchronous read/write bus with a two-bit offset. The data latch drives the eight data lines. The control register drives four control outputs, the data-line direction and an interrupt enable. The status view shows the peripheral's handshake inputs.

The acknowledge input (active low, asynchronous) passes through a two-flop synchroniser. When the interrupt enable is set, one chosen edge of that signal sets an interrupt request. The request is a level that stays high until the host clears it through the status offset. The parameter `ACK_RISE` picks the edge: 1 for low-to-high, 0 for high-to-low. The configuration input `bidir_mode` picks the behaviour. When it is low, the port is forward-only and the direction bit has no effect. When it is high, the direction bit turns the data lines around so they can be read back.

Top module: `lpt_ack_irq`

## Requirements
- R1: After reset, the data latch, the control outputs, the direction and the interrupt enable are all zero. `data_oe` is 1 and `irq` is 0.
- R2: A write to offset 0 loads the data latch onto `data_out` on the next clock edge. While the lines are driven, a read of offset 0 returns the latch.
- R3: A write to offset 2 loads control bits 3:0 onto `ctl_out`. A read of offset 2 returns {2'b00, direction, enable, ctl_out}.
- R4: With `bidir_mode` high, control bit 5 set to 1 makes `data_oe` 0, and a read of offset 0 then returns `data_in`.
- R5: With `bidir_mode` low, control bit 5 has no effect: `data_oe` stays 1, bit 5 reads back 0, and offset 0 returns the latch.
- R6: With control bit 4 set, the configured edge of `nack_in` raises `irq` on the third rising clock edge after the input changes.
- R7: The opposite edge of `nack_in` raises no request.
- R8: With control bit 4 clear, no edge raises `irq`. Writing bit 4 as 0 drops a pending request on that edge.
- R9: `irq` stays high until a write to offset 1 with bit 2 set. Status bit 2 reads the pending request.
- R10: Setting the enable while `nack_in` is static raises no request.
- R11: If a qualifying edge and a clear write land on the same clock edge, the request stays set.
- R12: With `data_out[7]` looped to `nack_in`, writing 0xFF and then 0x00 and then 0xFF raises exactly one request, on the configured edge.
- R13: A read of offset 1 returns: bit 7 the inverse of `status_in[3]`, bit 6 the synchronised acknowledge, bits 5:3 `status_in[2:0]`, bit 2 the pending request, and bits 1:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bidir_mode | input | 1 | 1 = bidirectional, 0 = forward-only |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected offset |
| data_out | output | 8 | Data latch to the data lines |
| data_oe | output | 1 | 1 = port drives the data lines |
| data_in | input | 8 | Data lines sensed back |
| ctl_out | output | 4 | Control outputs |
| status_in | input | 4 | Peripheral status lines (busy in bit 3) |
| nack_in | input | 1 | Asynchronous acknowledge, active low |
| irq | output | 1 | Level interrupt request |

## Verification
The interrupt logic has to resolve two actions that can land on the same clock edge: a qualifying acknowledge edge setting the request, and a host write clearing it. The bench raises `nack_in` and then places the clear write in the cycle in which the synchronised edge is present. The request must survive that write, and a later clear on its own must remove it. A second pairing puts a disabling control write against a pending request, and the request must drop on that same edge.

// File: rtl/lpt_ack_irq.sv
module lpt_ack_irq #(
  parameter bit ACK_RISE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bidir_mode,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] data_out,
  output logic       data_oe,
  input  logic [7:0] data_in,
  output logic [3:0] ctl_out,
  input  logic [3:0] status_in,
  input  logic       nack_in,
  output logic       irq
);
  logic [7:0] data_q;
  logic [3:0] ctl_q;
  logic       dir_q, ien_q, pend_q;
  logic       s1_q, s2_q, prev_q;

  wire wr_data = wr_en && addr == 2'd0;
  wire wr_stat = wr_en && addr == 2'd1;
  wire wr_ctl  = wr_en && addr == 2'd2;
  wire clr     = wr_stat && wdata[2];
  wire ien_d   = wr_ctl ? wdata[4] : ien_q;
  wire dir_eff = dir_q && bidir_mode;
  wire ack_edge = ACK_RISE ? (s2_q && !prev_q) : (!s2_q && prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
      dir_q  <= 1'b0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= nack_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      if (wr_data) data_q <= wdata;
      if (wr_ctl) begin
        ctl_q <= wdata[3:0];
        dir_q <= wdata[5] && bidir_mode;
      end
      ien_q  <= ien_d;
      pend_q <= ien_d && ((ien_q && ack_edge) || (pend_q && !clr));
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = dir_eff ? data_in : data_q;
      2'd1:    rdata = {!status_in[3], s2_q, status_in[2:0], pend_q, 2'b00};
      2'd2:    rdata = {2'b00, dir_eff, ien_q, ctl_q};
      default: rdata = 8'h00;
    endcase
  end

  assign data_out = data_q;
  assign data_oe  = !dir_eff;
  assign ctl_out  = ctl_q;
  assign irq      = pend_q;
endmodule

// File: rtl/lpt_ack_irq_chk.sv
module lpt_ack_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bidir_mode,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic       ien,
  input logic       irq
);
  // R8
  ien_gates_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);
  // R5
  fwd_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bidir_mode |-> data_oe);
  // R9
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && addr == 2'd1 && wdata[2]) && !(wr_en && addr == 2'd2)) |=> irq);
  // R6
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ien));
  // R2
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> data_out == $past(wdata));
endmodule

bind lpt_ack_irq lpt_ack_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bidir_mode(bidir_mode), .addr(addr),
  .wr_en(wr_en), .wdata(wdata), .data_out(data_out), .data_oe(data_oe),
  .ien(ien_q), .irq(irq)
);

// File: tb/lpt_ack_irq_test.sv
module lpt_ack_irq_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, bidir_mode = 0, wr_en = 0, nack_drv = 1, loop_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, data_in = 8'hA5;
  logic [3:0] status_in = 4'b0101;
  logic [7:0] rdata, data_out, rdata_f, data_out_f;
  logic data_oe, data_oe_f, irq, irq_f;
  logic [3:0] ctl_out, ctl_out_f;
  int n_chk = 0, n_bad = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wire nack_r = loop_en ? data_out[7] : nack_drv;
  wire nack_f = loop_en ? data_out_f[7] : nack_drv;

  lpt_ack_irq #(.ACK_RISE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bidir_mode(bidir_mode), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .data_out(data_out), .data_oe(data_oe),
    .data_in(data_in), .ctl_out(ctl_out), .status_in(status_in), .nack_in(nack_r), .irq(irq));
  lpt_ack_irq #(.ACK_RISE(1'b0)) uut_fall (
    .clk(clk), .rst_n(rst_n), .bidir_mode(bidir_mode), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata_f), .data_out(data_out_f), .data_oe(data_oe_f),
    .data_in(data_in), .ctl_out(ctl_out_f), .status_in(status_in), .nack_in(nack_f), .irq(irq_f));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 data_out", data_out, 8'h00);
    check("R1 ctl_out", {4'h0, ctl_out}, 8'h00);
    check("R1 oe/irq", {6'h0, data_oe, irq}, 8'h02);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(2'd0, 8'h3C);
    check("R2 data_out", data_out, 8'h3C);
    rd(2'd0, v); check("R2 readback", v, 8'h3C);
    wr(2'd2, 8'h0A);
    check("R3 ctl_out", {4'h0, ctl_out}, 8'h0A);
    rd(2'd2, v); check("R3 ctl read", v, 8'h0A);
    rd(2'd1, v); check("R13 status", v, {1'b1, 1'b1, 3'b101, 1'b0, 2'b00});
  endtask

  task automatic t_dir();
    logic [7:0] v;
    bidir_mode = 0;
    wr(2'd2, 8'h20);
    check("R5 oe", {7'h0, data_oe}, 8'h01);
    rd(2'd2, v); check("R5 bit5", v, 8'h00);
    rd(2'd0, v); check("R5 data", v, 8'h3C);
    bidir_mode = 1;
    wr(2'd2, 8'h20);
    check("R4 oe", {7'h0, data_oe}, 8'h00);
    rd(2'd0, v); check("R4 data_in", v, 8'hA5);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    wr(2'd2, 8'h10);
    idle(4);
    check("R10 no spurious", {6'h0, irq, irq_f}, 8'h00);
    nack_drv = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 pre", {7'h0, irq_f}, 8'h00);
    @(negedge clk);
    check("R6 fall edge", {7'h0, irq_f}, 8'h01);
    check("R7 wrong edge", {7'h0, irq}, 8'h00);
    nack_drv = 1; idle(4);
    check("R6 rise edge", {7'h0, irq}, 8'h01);
    idle(3);
    check("R9 held", {6'h0, irq, irq_f}, 8'h03);
    rd(2'd1, v); check("R9 status bit", {7'h0, v[2]}, 8'h01);
    wr(2'd1, 8'h04);
    check("R9 cleared", {6'h0, irq, irq_f}, 8'h00);
    wr(2'd2, 8'h00);
    nack_drv = 0; idle(4); nack_drv = 1; idle(4);
    check("R8 disabled", {6'h0, irq, irq_f}, 8'h00);
    wr(2'd2, 8'h10);
    nack_drv = 0; idle(5);
    check("R8 pend", {7'h0, irq_f}, 8'h01);
    wr(2'd2, 8'h00);
    check("R8 drop", {7'h0, irq_f}, 8'h00);
  endtask

  task automatic t_collide();
    wr(2'd2, 8'h10);
    wr(2'd1, 8'h04);
    @(negedge clk); nack_drv = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 2'd1; wdata = 8'h04; wr_en = 1;
    @(negedge clk); wr_en = 0;
    check("R11 set wins", {7'h0, irq}, 8'h01);
    wr(2'd1, 8'h04);
    check("R11 later clear", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_loop();
    wr(2'd0, 8'hFF);
    loop_en = 1; idle(5);
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h10); idle(4);
    check("R12 quiet", {6'h0, irq, irq_f}, 8'h00);
    wr(2'd0, 8'h00); idle(5);
    check("R12 after 00", {6'h0, irq, irq_f}, 8'h01);
    wr(2'd0, 8'hFF); idle(5);
    check("R12 after FF", {6'h0, irq, irq_f}, 8'h03);
    loop_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_dir();
    t_edges();
    t_collide();
    t_loop();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule